// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single memory requests from a small 8-bit controller core into timed bus cycles on external pins. It covers a 64K code space and a separate 64K data space. The core presents a 16-bit address, an access kind and write data. It gets back read data and a one-clock completion pulse. A free-running sequencer splits every machine cycle of 12 clocks into two halves of 6 clocks, called slots.

Each slot opens with an address-latch strobe. While that strobe is high, a shared low port carries the low address byte, so an external latch can hold it. The same port then carries the data in or out. A high port carries the upper address byte for the whole slot. Code fetches use their own active-low output enable. Data reads and writes use separate active-low strobes. A code fetch reads two consecutive bytes, one per slot. When the on-chip-code input is high, a code fetch makes no external access at all.

Top module: `ext_bus_ctrl`

## Requirements
- R1: The machine cycle is 12 clocks long. `req_ready` is high for exactly one clock in each cycle, and the first time is the 11th clock after reset is released. A request is taken only on a clock edge where `req_ready` and `req_valid` are both high. A `req_valid` that falls before `req_ready` rises causes no bus activity and no `rsp_done`.
- R2: In every slot, including idle slots, `adr_stb` is high during sub-phases 0 and 1 and low during sub-phases 2 to 5. This gives two pulses per machine cycle.
- R3: In an external slot, `bus_lo_out` carries the low address byte with `bus_lo_oe` high during sub-phases 0 and 1. `bus_hi` carries the high address byte for the whole slot.
- R4: `req_kind` 2'b00 is a code fetch. With `code_on_chip` low, `code_oe_n` is low in sub-phases 3 and 4 of both slots. Slot 0 uses the request address and slot 1 uses that address plus one, with 16-bit wrap. `rsp_rdata` is {byte from slot 1, byte from slot 0}.
- R5: A code fetch taken while `code_on_chip` is high drives none of the three strobes low and returns `rsp_rdata` = 0.
- R6: `req_kind` 2'b01 is a data read. `data_rd_n` is low in sub-phases 3 and 4 of slot 0 only, and `bus_lo_oe` is low from sub-phase 2 of that slot. The byte present at the end of sub-phase 4 is returned as {8'h00, byte}. `code_oe_n` stays high.
- R7: `req_kind` 2'b10 is a data write. `data_wr_n` is low in sub-phases 3 and 4 of slot 0. `bus_lo_out` carries the write data with `bus_lo_oe` high from sub-phase 2 to sub-phase 5, which is one clock past the rise of `data_wr_n`. `rsp_rdata` reads 0.
- R8: For each access taken, `rsp_done` is high for exactly one clock: the last clock of that machine cycle. `rsp_rdata` is valid then and holds until the next request is taken.
- R9: A synchronous active-low reset puts the sequencer at sub-phase 0 of slot 0. It drives all three strobes high, releases the low port, holds `rsp_done` low and drops any access in progress.
- R10: `req_kind` 2'b11 is not taken. It causes no strobe and no `rsp_done`, and leaves `rsp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one sub-phase per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Machine-cycle boundary; request taken on this edge |
| req_kind | input | 2 | 00 code fetch, 01 data read, 10 data write, 11 none |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| code_on_chip | input | 1 | High: code fetches stay internal |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result |
| bus_lo_out | output | 8 | Low port output value (address low byte, then data) |
| bus_lo_oe | output | 1 | Low port drive enable |
| bus_lo_in | input | 8 | Low port input value |
| bus_hi | output | 8 | High address byte |
| adr_stb | output | 1 | Address latch strobe, active high |
| code_oe_n | output | 1 | Code memory output enable, active low |
| data_rd_n | output | 1 | Data read strobe, active low |
| data_wr_n | output | 1 | Data write strobe, active low |

## Verification
Writes, reads and code fetches are interleaved back to back through a pin-level memory model. The model latches the address on the strobe. Reading back written data shows that the address and data phases of the shared port are placed correctly. Code fetches at 0x0100, 0x00FF and 0xFFFF show whether the second byte uses the incremented address, including a carry into the high port and a wrap to 0x0000. An internal fetch, a no-op kind and a request dropped before the boundary each show whether external activity is suppressed. A reset in the middle of a write shows whether strobes release at once and whether the cut-off access is dropped.

// File: rtl/ebc_pkg.sv
// Shared types for the external bus controller.
// Assumes a two-bit request kind as listed in the brief.
package ebc_pkg;

    typedef enum logic [1:0] {
        KIND_CODE = 2'b00,
        KIND_DRD  = 2'b01,
        KIND_DWR  = 2'b10,
        KIND_NOP  = 2'b11
    } bus_kind_e;

endpackage

// File: rtl/ebc_phase_seq.sv
// Oscillator-phase sequencer: counts sub-phases within a slot and slots
// within a machine cycle. Free-running from reset; assumes SUBS >= 5.
module ebc_phase_seq #(
    parameter int SUBS  = 6,
    parameter int SLOTS = 2,
    localparam int SUB_W  = $clog2(SUBS),
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SUB_W-1:0]  sub,
    output logic [SLOT_W-1:0] slot,
    output logic              slot_end,
    output logic              cyc_end
);

    // Last sub-phase of a slot and last slot of a machine cycle.
    always_comb begin
        slot_end = (sub == SUB_W'(SUBS - 1));
        cyc_end  = slot_end && (slot == SLOT_W'(SLOTS - 1));
    end

    // Advance the sub-phase, roll into the next slot and wrap the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub  <= '0;
            slot <= '0;
        end else if (slot_end) begin
            sub  <= '0;
            slot <= cyc_end ? '0 : slot + SLOT_W'(1);
        end else begin
            sub <= sub + SUB_W'(1);
        end
    end

    // R1: a slot always restarts at sub-phase 0 after its last sub-phase
    p_sub_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> (sub == '0));

    // R1: the machine cycle wraps to slot 0
    p_cycle_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> (slot == '0));

    // R1: sub-phases step by one inside a slot
    p_sub_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end |=> (sub == $past(sub) + SUB_W'(1)));

endmodule

// File: rtl/ebc_pin_map.sv
// Pin decoder: from the latched access and the current phase, forms the
// address strobe, the three active-low strobes, both ports and the read
// sample enable. Purely combinational; assumes SUBS >= 5 so that the
// address, turnaround, strobe and hold sub-phases do not overlap.
module ebc_pin_map
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SUBS   = 6,
    parameter int SLOTS  = 2,
    localparam int SUB_W  = $clog2(SUBS),
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int HI_W   = ADDR_W - DATA_W
) (
    input  logic              busy,
    input  bus_kind_e         kind,
    input  logic              on_chip,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SUB_W-1:0]  sub,
    input  logic [SLOT_W-1:0] slot,
    output logic              adr_stb,
    output logic              code_oe_n,
    output logic              data_rd_n,
    output logic              data_wr_n,
    output logic [DATA_W-1:0] lo_out,
    output logic              lo_oe,
    output logic [HI_W-1:0]   hi_out,
    output logic              sample_en
);

    localparam int ADR_SUBS   = 2;
    localparam int STRB_FIRST = 3;
    localparam int STRB_LAST  = SUBS - 2;

    logic              code_slot;
    logic              data_slot;
    logic              slot_act;
    logic              strobe_win;
    logic              addr_win;
    logic [ADDR_W-1:0] slot_addr;

    // Classify the current slot and the current window within it.
    always_comb begin
        code_slot  = busy && (kind == KIND_CODE) && !on_chip;
        data_slot  = busy && ((kind == KIND_DRD) || (kind == KIND_DWR)) && (slot == '0);
        slot_act   = code_slot || data_slot;
        slot_addr  = base_addr + ADDR_W'(slot);
        addr_win   = (sub < SUB_W'(ADR_SUBS));
        strobe_win = (sub >= SUB_W'(STRB_FIRST)) && (sub <= SUB_W'(STRB_LAST));
    end

    // Strobes: address strobe every slot, access strobes in the strobe window.
    always_comb begin
        adr_stb   = addr_win;
        code_oe_n = !(code_slot && strobe_win);
        data_rd_n = !(data_slot && (kind == KIND_DRD) && strobe_win);
        data_wr_n = !(data_slot && (kind == KIND_DWR) && strobe_win);
        sample_en = (code_slot || (data_slot && (kind == KIND_DRD)))
                    && (sub == SUB_W'(STRB_LAST));
    end

    // Shared low port: address first, then write data or released.
    always_comb begin
        lo_out = '0;
        lo_oe  = 1'b0;
        if (slot_act && addr_win) begin
            lo_out = slot_addr[DATA_W-1:0];
            lo_oe  = 1'b1;
        end else if (data_slot && (kind == KIND_DWR)) begin
            lo_out = wdata;
            lo_oe  = 1'b1;
        end
        hi_out = slot_act ? slot_addr[ADDR_W-1:DATA_W] : '0;
    end

endmodule

// File: rtl/ebc_rd_capture.sv
// Read capture: one byte register per slot, loaded from the low port on
// the sample enable of its slot and cleared when a new access is taken.
module ebc_rd_capture #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 2,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    sample_en,
    input  logic [SLOT_W-1:0]       slot,
    input  logic [DATA_W-1:0]       din,
    output logic [SLOTS*DATA_W-1:0] dout
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_byte
        // Hold the byte read during slot g.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                dout[g*DATA_W +: DATA_W] <= '0;
            end else if (sample_en && (slot == SLOT_W'(g))) begin
                dout[g*DATA_W +: DATA_W] <= din;
            end
        end
    end

endmodule

// File: rtl/ext_bus_ctrl.sv
// External bus controller top. Takes one request per machine cycle at
// the cycle boundary, runs it over the following machine cycle and
// pulses done on its last clock. Assumes the core holds the request
// until req_ready and that external memory answers within two clocks
// of its strobe falling.
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SUBS   = 6,
    parameter int SLOTS  = 2,
    localparam int SUB_W  = $clog2(SUBS),
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int HI_W   = ADDR_W - DATA_W,
    localparam int RD_W   = SLOTS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              code_on_chip,
    output logic              rsp_done,
    output logic [RD_W-1:0]   rsp_rdata,
    output logic [DATA_W-1:0] bus_lo_out,
    output logic              bus_lo_oe,
    input  logic [DATA_W-1:0] bus_lo_in,
    output logic [HI_W-1:0]   bus_hi,
    output logic              adr_stb,
    output logic              code_oe_n,
    output logic              data_rd_n,
    output logic              data_wr_n
);

    logic [SUB_W-1:0]  sub;
    logic [SLOT_W-1:0] slot;
    logic              slot_end;
    logic              cyc_end;
    logic              busy;
    bus_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              on_chip_q;
    logic              accept;
    logic              sample_en;

    ebc_phase_seq #(.SUBS(SUBS), .SLOTS(SLOTS)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub      (sub),
        .slot     (slot),
        .slot_end (slot_end),
        .cyc_end  (cyc_end)
    );

    // Boundary handshake and the one-clock completion pulse.
    always_comb begin
        req_ready = cyc_end;
        accept    = cyc_end && req_valid && (bus_kind_e'(req_kind) != KIND_NOP);
        rsp_done  = busy && cyc_end;
    end

    // Latch an access at the boundary; busy lasts one machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            kind_q    <= KIND_NOP;
            addr_q    <= '0;
            wdata_q   <= '0;
            on_chip_q <= 1'b0;
        end else if (cyc_end) begin
            busy <= accept;
            if (accept) begin
                kind_q    <= bus_kind_e'(req_kind);
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
                on_chip_q <= code_on_chip;
            end
        end
    end

    ebc_pin_map #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUBS(SUBS), .SLOTS(SLOTS)
    ) i_pins (
        .busy      (busy),
        .kind      (kind_q),
        .on_chip   (on_chip_q),
        .base_addr (addr_q),
        .wdata     (wdata_q),
        .sub       (sub),
        .slot      (slot),
        .adr_stb   (adr_stb),
        .code_oe_n (code_oe_n),
        .data_rd_n (data_rd_n),
        .data_wr_n (data_wr_n),
        .lo_out    (bus_lo_out),
        .lo_oe     (bus_lo_oe),
        .hi_out    (bus_hi),
        .sample_en (sample_en)
    );

    ebc_rd_capture #(.DATA_W(DATA_W), .SLOTS(SLOTS)) i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample_en (sample_en),
        .slot      (slot),
        .din       (bus_lo_in),
        .dout      (rsp_rdata)
    );

    // R1: an access starts only at the first sub-phase of a machine cycle
    p_accept_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sub == '0) && (slot == '0));

    // R2: the address strobe rises only at the start of a slot
    p_adr_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adr_stb) |-> (sub == '0));

    // R5: an on-chip code fetch leaves every strobe inactive
    p_on_chip_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (kind_q == KIND_CODE) && on_chip_q) |-> (code_oe_n && data_rd_n && data_wr_n));

    // R6: the low port is released whenever a read strobe is low
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_rd_n || !code_oe_n) |-> !bus_lo_oe);

    // R6: data accesses never enable code memory
    p_no_code_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (kind_q != KIND_CODE)) |-> code_oe_n);

    // R6: at most one access strobe is low at a time
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!code_oe_n, !data_rd_n, !data_wr_n}) <= 1);

    // R7: write data is still driven, unchanged, on the clock after the write strobe rises
    p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_wr_n) |-> bus_lo_oe && (bus_lo_out == $past(bus_lo_out)));

    // R8: completion is a single-clock pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/test_ext_bus_ctrl.sv
// Bench for ext_bus_ctrl: a table of accesses walked back to back
// through a pin-level memory model, then directed tests.
module test_ext_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        code_on_chip = 1'b0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [7:0]  bus_lo_out;
    logic        bus_lo_oe;
    logic [7:0]  bus_lo_in = 8'hEE;
    logic [7:0]  bus_hi;
    logic        adr_stb;
    logic        code_oe_n;
    logic        data_rd_n;
    logic        data_wr_n;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ext_bus_ctrl i_ext_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .code_on_chip(code_on_chip), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_lo_out(bus_lo_out), .bus_lo_oe(bus_lo_oe), .bus_lo_in(bus_lo_in),
        .bus_hi(bus_hi), .adr_stb(adr_stb), .code_oe_n(code_oe_n),
        .data_rd_n(data_rd_n), .data_wr_n(data_wr_n)
    );

    function automatic logic [7:0] code_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] code_pair(input logic [15:0] a);
        logic [15:0] b;
        b = a + 16'd1;
        return {code_byte(b), code_byte(a)};
    endfunction

    typedef struct packed {
        logic [1:0]  kind;
        logic        on_chip;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 1'b0, 16'h1234, 8'hA5, 16'h0000},
        '{2'd1, 1'b0, 16'h1234, 8'h00, 16'h00A5},
        '{2'd0, 1'b0, 16'h0100, 8'h00, code_pair(16'h0100)},
        '{2'd0, 1'b0, 16'h00FF, 8'h00, code_pair(16'h00FF)},
        '{2'd0, 1'b0, 16'hFFFF, 8'h00, code_pair(16'hFFFF)},
        '{2'd2, 1'b0, 16'h8077, 8'h3C, 16'h0000},
        '{2'd1, 1'b0, 16'h8077, 8'h00, 16'h003C},
        '{2'd0, 1'b1, 16'h2000, 8'h00, 16'h0000},
        '{2'd1, 1'b0, 16'h4410, 8'h00, 16'h00D3},
        '{2'd2, 1'b0, 16'h00FE, 8'h00, 16'h0000},
        '{2'd1, 1'b0, 16'h00FE, 8'h00, 16'h0000}
    };

    // Pin-level memory model and monitor state.
    logic [7:0]  dmem [256];
    logic [15:0] lat_addr = '0;
    logic [7:0]  cur_wdata = '0;
    logic [7:0]  wr_seen = '0;
    int n_adr_hi = 0, n_adr_rise = 0, n_code = 0, n_rd = 0, n_wr = 0, n_done = 0;
    int v_release = 0, v_hi = 0, v_wdat = 0, v_hold = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor and memory model, sampled 2 ns after each rising edge.
    initial begin
        logic p_adr, p_code, p_rd, p_wr;
        for (int i = 0; i < 256; i++) dmem[i] = 8'(i) ^ 8'hC3;
        p_adr = 1'b0; p_code = 1'b1; p_rd = 1'b1; p_wr = 1'b1;
        forever begin
            @(posedge clk);
            #2;
            if (adr_stb) n_adr_hi++;
            if (adr_stb && !p_adr) n_adr_rise++;
            if (!code_oe_n && p_code) n_code++;
            if (!data_rd_n && p_rd) n_rd++;
            if (!data_wr_n && p_wr) n_wr++;
            if (rsp_done) n_done++;
            if (adr_stb && bus_lo_oe) lat_addr = {bus_hi, bus_lo_out};
            if ((!data_rd_n || !code_oe_n) && bus_lo_oe) v_release++;
            if ((!data_rd_n || !code_oe_n || !data_wr_n) && bus_hi != lat_addr[15:8]) v_hi++;
            if (!data_wr_n) begin
                wr_seen = bus_lo_out;
                if (!bus_lo_oe || bus_lo_out != cur_wdata) v_wdat++;
            end
            if (data_wr_n && !p_wr && rst_n) begin
                if (!bus_lo_oe || bus_lo_out != cur_wdata) v_hold++;
                dmem[lat_addr[7:0]] = wr_seen;
            end
            if (!code_oe_n) bus_lo_in = code_byte(lat_addr);
            else if (!data_rd_n) bus_lo_in = dmem[lat_addr[7:0]];
            else bus_lo_in = 8'hEE;
            p_adr = adr_stb; p_code = code_oe_n; p_rd = data_rd_n; p_wr = data_wr_n;
        end
    end

    task automatic wait_ready();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    // Runs one access; starts and ends on a negedge with req_ready high.
    task automatic run_vec(input vec_t v, input int idx);
        int s_hi, s_rise, s_code, s_rd, s_wr, s_done;
        string rt;
        req_valid = 1'b1; req_kind = v.kind; req_addr = v.addr;
        req_wdata = v.wdata; code_on_chip = v.on_chip; cur_wdata = v.wdata;
        s_hi = n_adr_hi; s_rise = n_adr_rise; s_code = n_code;
        s_rd = n_rd; s_wr = n_wr; s_done = n_done;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        check($sformatf("R8 no early done vec%0d", idx), rsp_done, 1'b0);
        @(negedge clk);
        check($sformatf("R8 done on last clock vec%0d", idx), rsp_done, 1'b1);
        check($sformatf("R1 ready at boundary vec%0d", idx), req_ready, 1'b1);
        rt = (v.kind == 2'd0) ? (v.on_chip ? "R5" : "R4") : (v.kind == 2'd1) ? "R6" : "R7";
        check($sformatf("%s rdata vec%0d", rt, idx), rsp_rdata, v.exp);
        check($sformatf("R2 strobe high clocks vec%0d", idx), n_adr_hi - s_hi, 4);
        check($sformatf("R2 strobe pulses vec%0d", idx), n_adr_rise - s_rise, 2);
        check($sformatf("R4 code enables vec%0d", idx), n_code - s_code,
              (v.kind == 2'd0 && !v.on_chip) ? 2 : 0);
        check($sformatf("R6 read strobes vec%0d", idx), n_rd - s_rd, (v.kind == 2'd1) ? 1 : 0);
        check($sformatf("R7 write strobes vec%0d", idx), n_wr - s_wr, (v.kind == 2'd2) ? 1 : 0);
        check($sformatf("R8 one done vec%0d", idx), n_done - s_done, 1);
    endtask

    initial begin
        int s_rd, s_wr, s_done, s_code;
        logic [15:0] held;
        // R9: state while reset is held.
        repeat (3) @(negedge clk);
        check("R9 reset code_oe_n", code_oe_n, 1'b1);
        check("R9 reset data_rd_n", data_rd_n, 1'b1);
        check("R9 reset data_wr_n", data_wr_n, 1'b1);
        check("R9 reset port released", bus_lo_oe, 1'b0);
        check("R9 reset done low", rsp_done, 1'b0);
        check("R9 reset rdata zero", rsp_rdata, 16'h0000);
        rst_n = 1'b1;
        // R1: first boundary on the 11th clock after release.
        repeat (10) @(negedge clk);
        check("R1 ready low before boundary", req_ready, 1'b0);
        @(negedge clk);
        check("R1 ready on 11th clock", req_ready, 1'b1);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R1: a request dropped before the boundary is ignored.
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_addr = 16'h1234;
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
        s_rd = n_rd; s_done = n_done;
        repeat (13) @(negedge clk);
        check("R1 dropped request no read", n_rd - s_rd, 0);
        check("R1 dropped request no done", n_done - s_done, 0);

        // R10: kind 11 is not taken.
        wait_ready();
        held = rsp_rdata;
        req_valid = 1'b1; req_kind = 2'd3; req_addr = 16'h5555;
        s_rd = n_rd; s_wr = n_wr; s_done = n_done; s_code = n_code;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (11) @(negedge clk);
        check("R10 no-op no strobes", (n_rd - s_rd) + (n_wr - s_wr) + (n_code - s_code), 0);
        check("R10 no-op no done", n_done - s_done, 0);
        check("R10 no-op rdata held", rsp_rdata, held);

        // R9: reset in the middle of a write.
        wait_ready();
        req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'h0055; req_wdata = 8'h77;
        cur_wdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 write strobe low at sub-phase 3", data_wr_n, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset releases write strobe", data_wr_n, 1'b1);
        check("R9 reset releases port", bus_lo_oe, 1'b0);
        check("R9 reset done low", rsp_done, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        s_wr = n_wr; s_done = n_done;
        repeat (12) @(negedge clk);
        check("R9 dropped access no write", n_wr - s_wr, 0);
        check("R9 dropped access no done", n_done - s_done, 0);

        // Pin timing seen by the monitor across the whole run.
        check("R6 port released under read strobes", v_release, 0);
        check("R3 high port matches latched address", v_hi, 0);
        check("R7 write data under write strobe", v_wdat, 0);
        check("R7 write data held past strobe", v_hold, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule